// File: doc/BRIEF.md
# Buck Gate Drive Sequencer

This block sits between a phase controller and the two gate drivers of one synchronous buck phase. It receives a decoded two-bit phase command (drive high, drive low, or float) and produces the enables for the high-side and low-side gates. Overlap is prevented by adaptive dead time. A gate turns on only after a comparator reports that the opposite gate has fallen below its turn-on threshold, so the dead time follows the real gate edges rather than a fixed delay.

Overrides sit on top of the sequencing:

- An active-low disable and an undervoltage-good input force both gates off in the same cycle.
- A float command turns both gates off.
- An optional diode-emulation mode stops the low side once the inductor current reaches zero.

If the expected gate-low feedback does not arrive within a programmable number of cycles, a fault flag is raised and the waiting gate stays off.

Top module: `gdrv_seq_top`

## Requirements
- R1: While `dsbl_n` is 0, `gh_en` and `gl_en` are both 0 in that same cycle. The internal gate state and `fault` are cleared at the next clock edge.
- R2: While `uvlo_ok` is 0, `gh_en` and `gl_en` are both 0 in that same cycle, with no clock edge needed, and the internal state is cleared as for R1. When `uvlo_ok` returns with a high command and the low-side feedback already high, `gh_en` rises at the first edge.
- R3: `cmd` is encoded as 2'b01 = drive high, 2'b00 = drive low, 2'b10 or 2'b11 = float. A float command makes both enables 0 one clock edge after it is applied.
- R4: On a high command, `gl_en` falls at the first edge. `gh_en` rises at the first edge at which `gl_en` is already 0 and `gl_low` is 1. While `gl_low` stays 0, `gh_en` stays 0.
- R5: On a low command, `gh_en` falls at the first edge. `gl_en` rises at the first edge at which `gh_en` is already 0 and `gh_low` is 1.
- R6: `gh_en` and `gl_en` are never 1 in the same cycle.
- R7: With `smod_n` = 0 and a low command, `zc` = 1 makes `gl_en` fall at the next edge. With `smod_n` = 1, `zc` has no effect.
- R8: A low side stopped by R7 stays off even after `zc` returns to 0. It comes back only after `gh_en` has been 1 (a high command was served), or after `smod_n` goes to 1.
- R9: A cycle is stalled when a gate is requested and still off while the opposite gate's low flag is 0. `fault` rises at the edge that ends `dt_limit` consecutive stalled cycles (`dt_limit` ≥ 1). It stays 1 until R1 or R2 clears it, and the waiting gate stays off while the flag is missing.
- R10: While `rst` is 1, `gh_en`, `gl_en` and `fault` are 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Phase command: 01 high, 00 low, 10/11 float |
| dsbl_n | input | 1 | Active-low disable |
| smod_n | input | 1 | Active-low diode-emulation enable |
| uvlo_ok | input | 1 | Supply above lockout threshold |
| zc | input | 1 | Inductor current at or below zero |
| gh_low | input | 1 | High-side gate sensed below threshold |
| gl_low | input | 1 | Low-side gate sensed below threshold |
| dt_limit | input | LIMIT_W | Stalled cycles before fault |
| gh_en | output | 1 | High-side gate enable |
| gl_en | output | 1 | Low-side gate enable |
| fault | output | 1 | Dead-time feedback timeout flag |

## Verification
The main sweep tries all 64 static combinations of disable, lockout, skip enable, command code and zero-cross flag. Each combination is preceded by a served high command, so the settled outputs separate the override priorities, the two float codes, and skip mode from normal low drive. Directed sequences then hold a feedback flag low for chosen cycle counts. These show that the gate-on edge tracks the feedback rather than a fixed delay, and that the fault rises on exactly the `dt_limit`-th stalled cycle. Further sequences toggle the zero-cross flag after a skip stop to show it persists until a high command is served, and drop lockout or disable between edges to show the clamp is immediate.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  typedef enum logic [1:0] {
    TGT_OFF = 2'd0,
    TGT_HI  = 2'd1,
    TGT_LO  = 2'd2
  } target_t;

  function automatic target_t decode_cmd(input logic [1:0] c);
    case (c)
      2'b01:   decode_cmd = TGT_HI;
      2'b00:   decode_cmd = TGT_LO;
      default: decode_cmd = TGT_OFF;
    endcase
  endfunction
endpackage

// File: rtl/gdrv_skip.sv
module gdrv_skip (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic smod_n,
  input  logic zc,
  input  logic tgt_lo,
  input  logic gh_served,
  output logic stop_now
);
  logic stop_q;

  always_comb stop_now = !smod_n && (stop_q || (zc && tgt_lo));

  always_ff @(posedge clk) begin
    if (rst || hold || smod_n || gh_served) stop_q <= 1'b0;
    else                                    stop_q <= stop_now;
  end

  // R7: a latched stop only begins from a zero crossing in skip mode
  p_skip_set_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_q) |-> $past(!smod_n && zc && tgt_lo));

  // R8: a served high command releases the stop
  p_skip_clear_r8: assert property (@(posedge clk) disable iff (rst)
    gh_served |=> !stop_q);
endmodule

// File: rtl/gdrv_deadtime.sv
module gdrv_deadtime #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic               want_hi,
  input  logic               want_lo,
  input  logic               gh_low,
  input  logic               gl_low,
  input  logic [LIMIT_W-1:0] limit,
  output logic               gh_q,
  output logic               gl_q,
  output logic               fault_q
);
  localparam logic [LIMIT_W-1:0] CNT_MAX = '1;

  logic [LIMIT_W-1:0] stall_cnt;
  logic [LIMIT_W:0]   stall_next;
  logic stall_hi, stall_lo, stalled, reached, gh_d, gl_d;

  always_comb begin
    stall_hi   = want_hi && !gh_q && !gl_low;
    stall_lo   = want_lo && !gl_q && !gh_low;
    stalled    = stall_hi || stall_lo;
    stall_next = {1'b0, stall_cnt} + 1'b1;
    reached    = stall_next >= {1'b0, limit};
    gh_d       = want_hi && !gl_q && (gh_q || gl_low);
    gl_d       = want_lo && !gh_q && (gl_q || gh_low);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      gh_q      <= 1'b0;
      gl_q      <= 1'b0;
      fault_q   <= 1'b0;
      stall_cnt <= '0;
    end else begin
      gh_q <= gh_d;
      gl_q <= gl_d;
      if (!stalled)                  stall_cnt <= '0;
      else if (stall_cnt != CNT_MAX) stall_cnt <= stall_cnt + 1'b1;
      if (stalled && reached) fault_q <= 1'b1;
    end
  end

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(gh_q && gl_q));

  p_gh_after_gl_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gh_q) |-> $past(gl_low && !gl_q));

  p_gl_after_gh_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(gl_q) |-> $past(gh_low && !gh_q));

  p_hold_clears_r1: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!gh_q && !gl_q && !fault_q));

  p_float_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!want_hi && !want_lo) |=> (!gh_q && !gl_q));

  p_fault_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> $past(stalled));
endmodule

// File: rtl/gdrv_seq_top.sv
module gdrv_seq_top #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cmd,
  input  logic               dsbl_n,
  input  logic               smod_n,
  input  logic               uvlo_ok,
  input  logic               zc,
  input  logic               gh_low,
  input  logic               gl_low,
  input  logic [LIMIT_W-1:0] dt_limit,
  output logic               gh_en,
  output logic               gl_en,
  output logic               fault
);
  import gdrv_pkg::*;

  target_t tgt;
  logic run, hold, stop_now, want_hi, want_lo, gh_q, gl_q;

  always_comb begin
    tgt     = decode_cmd(cmd);
    run     = dsbl_n && uvlo_ok;
    hold    = !run;
    want_hi = (tgt == TGT_HI);
    want_lo = (tgt == TGT_LO) && !stop_now;
  end

  gdrv_skip u_skip (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .smod_n    (smod_n),
    .zc        (zc),
    .tgt_lo    (tgt == TGT_LO),
    .gh_served (gh_q),
    .stop_now  (stop_now)
  );

  gdrv_deadtime #(.LIMIT_W(LIMIT_W)) u_dt (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .want_hi (want_hi),
    .want_lo (want_lo),
    .gh_low  (gh_low),
    .gl_low  (gl_low),
    .limit   (dt_limit),
    .gh_q    (gh_q),
    .gl_q    (gl_q),
    .fault_q (fault)
  );

  // Clamp is combinational so a lockout or disable acts within the cycle.
  assign gh_en = gh_q && run;
  assign gl_en = gl_q && run;

  p_clamp_r2: assert property (@(posedge clk) disable iff (rst)
    !uvlo_ok |-> (!gh_en && !gl_en));

  p_port_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(gh_en && gl_en));
endmodule

// File: tb/gdrv_seq_top_test.sv
module gdrv_seq_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd = 2'b10;
  logic       dsbl_n = 1'b1, smod_n = 1'b1, uvlo_ok = 1'b1, zc = 1'b0;
  logic       gh_hold_fb = 1'b0, gl_hold_fb = 1'b0;
  logic [7:0] dt_limit = 8'd200;
  logic       gh_en, gl_en, fault, gh_low, gl_low;
  int checks = 0, bad = 0, overlap = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Instant comparator model, with a hook to hold a flag low.
  assign gh_low = !gh_en && !gh_hold_fb;
  assign gl_low = !gl_en && !gl_hold_fb;

  gdrv_seq_top uut (
    .clk(clk), .rst(rst), .cmd(cmd), .dsbl_n(dsbl_n), .smod_n(smod_n),
    .uvlo_ok(uvlo_ok), .zc(zc), .gh_low(gh_low), .gl_low(gl_low),
    .dt_limit(dt_limit), .gh_en(gh_en), .gl_en(gl_en), .fault(fault)
  );

  always @(negedge clk) if (!rst && gh_en && gl_en) overlap++;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {gh,gl,fault} got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {gh_en, gl_en, fault};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R10 reset", outs(), 3'b000);
    rst = 1'b0;

    // Exhaustive static sweep: R1 R2 R3 R7
    for (int dn = 0; dn < 2; dn++)
      for (int uv = 0; uv < 2; uv++)
        for (int sm = 0; sm < 2; sm++)
          for (int c = 0; c < 4; c++)
            for (int z = 0; z < 2; z++) begin
              logic [2:0] e;
              dsbl_n = 1; uvlo_ok = 1; smod_n = 1; zc = 0; cmd = 2'b01;
              step(3);
              dsbl_n = dn[0]; uvlo_ok = uv[0]; smod_n = sm[0];
              cmd = c[1:0]; zc = z[0];
              step(4);
              if (dn == 0 || uv == 0) e = 3'b000;
              else if (c == 1)        e = 3'b100;
              else if (c >= 2)        e = 3'b000;
              else if (sm == 0 && z == 1) e = 3'b000;
              else                    e = 3'b010;
              chk("R1/R2/R3/R7 sweep", outs(), e);
            end
    dsbl_n = 1; uvlo_ok = 1; smod_n = 1; zc = 0;

    // R4 / R5 one-cycle dead time with instant feedback
    cmd = 2'b00; step(4);
    cmd = 2'b01; step(1);
    chk("R4 dead cycle", outs(), 3'b000);
    step(1);
    chk("R4 gh on", outs(), 3'b100);
    cmd = 2'b00; step(1);
    chk("R5 dead cycle", outs(), 3'b000);
    step(1);
    chk("R5 gl on", outs(), 3'b010);

    // R4 delayed feedback
    gl_hold_fb = 1; cmd = 2'b01; step(3);
    chk("R4 wait feedback", outs(), 3'b000);
    gl_hold_fb = 0; step(1);
    chk("R4 gh after feedback", outs(), 3'b100);

    // R9 timeout
    cmd = 2'b00; step(3);
    dt_limit = 8'd5; gl_hold_fb = 1; cmd = 2'b01;
    step(4);
    chk("R9 before limit", outs(), 3'b000);
    step(1);
    chk("R9 fault at limit", outs(), 3'b001);
    gl_hold_fb = 0; step(1);
    chk("R9 sticky", outs(), 3'b101);
    dsbl_n = 0; step(1);
    chk("R1 clears fault", outs(), 3'b000);
    dsbl_n = 1; dt_limit = 8'd200;

    // R8 skip persistence
    smod_n = 0; cmd = 2'b00; step(4);
    chk("R7 gl before zc", outs(), 3'b010);
    zc = 1; step(1);
    chk("R7 zc stops gl", outs(), 3'b000);
    zc = 0; step(3);
    chk("R8 stays off", outs(), 3'b000);
    cmd = 2'b01; step(2);
    chk("R8 high served", outs(), 3'b100);
    cmd = 2'b00; step(2);
    chk("R8 gl back", outs(), 3'b010);
    zc = 1; step(1); zc = 0; smod_n = 1; step(1);
    chk("R8 smod_n clears", outs(), 3'b010);

    // R2 / R1 immediate clamp
    cmd = 2'b01; step(3);
    uvlo_ok = 0; #1;
    chk("R2 immediate clamp", outs(), 3'b000);
    step(1);
    uvlo_ok = 1; step(1);
    chk("R2 restart", outs(), 3'b100);
    dsbl_n = 0; #1;
    chk("R1 immediate clamp", outs(), 3'b000);
    dsbl_n = 1; step(2);

    // R3 float from high
    cmd = 2'b11; step(1);
    chk("R3 float", outs(), 3'b000);

    checks++;
    if (overlap != 0) begin
      bad++;
      $display("FAIL R6: overlap cycles got %0d expected 0", overlap);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule